// File: doc/BRIEF.md
# SPI Master Shift Engine with Programmable Baud Divider

This block is a master-only serial engine. It moves one parallel word out on a serial data line, most significant bit first, and gathers the bits returned on the input line into a parallel word. The serial clock is made from the faster system clock by a divide ratio set through a 7-bit baud field. A single polarity input sets the level that the serial clock rests at. The engine works in the no-delay phase mode: each bit is put on the output line at the edge that leaves the rest level, and the input line is sampled at the edge that returns to it.

A host loads the word, the baud field and the polarity, and then pulses `start` for one cycle. The engine raises `busy` and pulls the active-low select down. It runs the configured number of bits and then releases the select. In that same cycle it pulses `done` and presents the received word. The configuration is captured when the transfer is accepted, so the host may change its inputs while a transfer is running.

Top module: `spi_baud_master`

## Requirements
- R1: The divide ratio N is baud+1 system clocks per serial clock cycle when baud is 3 or more, and N is 4 when baud is 0, 1 or 2. N therefore spans 4 to 128, and successive sampling edges are N cycles apart.
- R2: Each serial clock cycle starts with floor(N/2) cycles at the active level (the inverse of `cpol`) and ends with ceil(N/2) cycles at the rest level (`cpol`). For even N both halves are equal. For odd N the first half is one cycle shorter.
- R3: After reset and whenever no transfer runs, `sclk` sits at the level of `cpol` one cycle after `cpol` is applied. In that state `cs_n` is 1, `busy` is 0 and `done` is 0.
- R4: In the cycle after `start` is accepted, `cs_n` goes to 0, `sclk` goes to the active level and `mosi` shows bit CHAR_LEN-1 of `tx_data`. So the first bit leads the first sampling edge by floor(N/2) cycles. Each following bit, in order from most to least significant, appears on a move from the rest level to the active level.
- R5: `miso` is sampled on each move of `sclk` from the active level to the rest level. The first sample lands in bit CHAR_LEN-1 of `rx_data` and the last sample in bit 0.
- R6: `busy` stays high for exactly CHAR_LEN*N cycles. `cs_n` rises and `done` pulses for one cycle when `busy` falls, which is ceil(N/2) cycles after the last sampling edge. `rx_data` is updated in that cycle and then holds its value.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It neither lengthens the running transfer nor causes a second one.
- R8: The values of `baud`, `cpol` and `tx_data` are captured when the transfer is accepted. Changing these inputs during a transfer does not alter its timing, its levels or its transmitted bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock from which the serial clock is divided |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transfer |
| baud | input | 7 | Baud field that sets the divide ratio |
| cpol | input | 1 | Rest level of the serial clock |
| tx_data | input | CHAR_LEN | Word to transmit |
| miso | input | 1 | Serial data returned from the slave |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle pulse when a transfer completes |
| rx_data | output | CHAR_LEN | Received word, valid from `done` onward |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data toward the slave |
| cs_n | output | 1 | Active-low slave select |

## Verification
The bench builds the engine with an 8-bit character, so each transfer has eight sampling edges and a full byte can be checked. Baud values 0 through 4, 7, 10 and 127 bring within reach the forced ratio of 4, the threshold at 3, short and long odd ratios with their uneven halves, and the largest ratio of 128. The bench also covers both polarities, a start request injected mid-transfer, and input changes made mid-transfer.

// File: rtl/spi_sm_pkg.sv
package spi_sm_pkg;

    localparam int BAUD_W      = 7;
    localparam int RATIO_W     = BAUD_W + 1;
    localparam int FIXED_RATIO = 4;
    localparam int FIXED_TOP   = 2;

    typedef logic [BAUD_W-1:0]  baud_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_ACTIVE,
        XS_REST,
        XS_TAIL
    } xfer_state_e;

    typedef struct packed {
        logic   pol;
        ratio_t lead_len;
        ratio_t rest_len;
    } xfer_cfg_t;

    typedef struct packed {
        logic load;
        logic launch;
        logic sample;
        logic finish;
    } shift_cmd_t;

    function automatic ratio_t ratio_of(input baud_t b);
        ratio_t r;
        if (int'(b) <= FIXED_TOP) r = RATIO_W'(FIXED_RATIO);
        else                      r = RATIO_W'(b) + RATIO_W'(1);
        return r;
    endfunction

endpackage

// File: rtl/spi_rate_calc.sv
module spi_rate_calc
    import spi_sm_pkg::*;
(
    input  baud_t  baud,
    output ratio_t lead_len,
    output ratio_t rest_len
);
    ratio_t ratio;

    always_comb begin
        ratio    = ratio_of(baud);
        lead_len = ratio >> 1;
        rest_len = ratio - (ratio >> 1);
    end

    always_comb begin
        a_r1_ratio_floor: assert (ratio >= RATIO_W'(FIXED_RATIO));
    end
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer
    import spi_sm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  ratio_t load_val,
    output logic   expire
);
    ratio_t cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - RATIO_W'(1);
    end

    assign expire = (cnt == '0);

    a_r2_load_on_expiry: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt == '0));
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
    import spi_sm_pkg::*;
#(
    parameter int CHAR_LEN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  shift_cmd_t          cmd,
    input  logic [CHAR_LEN-1:0] tx_word,
    input  logic                miso,
    output logic                mosi,
    output logic [CHAR_LEN-1:0] rx_word,
    output logic                last_bit
);
    localparam int BC_W = $clog2(CHAR_LEN + 1);

    logic [CHAR_LEN-1:0] tx_sh;
    logic [CHAR_LEN-1:0] rx_sh;
    logic [CHAR_LEN:0]   rx_wide;
    logic [BC_W-1:0]     bit_cnt;

    always_comb rx_wide = {rx_sh, miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else begin
            if (cmd.load) begin
                tx_sh   <= tx_word;
                rx_sh   <= '0;
                bit_cnt <= '0;
            end
            if (cmd.sample) begin
                rx_sh   <= rx_wide[CHAR_LEN-1:0];
                bit_cnt <= bit_cnt + BC_W'(1);
            end
            if (cmd.launch) tx_sh <= tx_sh << 1;
            if (cmd.finish) tx_sh <= '0;
        end
    end

    assign mosi     = tx_sh[CHAR_LEN-1];
    assign rx_word  = rx_sh;
    assign last_bit = (bit_cnt == BC_W'(CHAR_LEN - 1));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= BC_W'(CHAR_LEN));
    a_r4_launch_apart: assert property (@(posedge clk) disable iff (rst)
        !(cmd.launch && cmd.sample));
endmodule

// File: rtl/spi_baud_master.sv
module spi_baud_master
    import spi_sm_pkg::*;
#(
    parameter int CHAR_LEN = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [6:0]          baud,
    input  logic                cpol,
    input  logic [CHAR_LEN-1:0] tx_data,
    input  logic                miso,
    output logic                busy,
    output logic                done,
    output logic [CHAR_LEN-1:0] rx_data,
    output logic                sclk,
    output logic                mosi,
    output logic                cs_n
);
    xfer_state_e         st;
    xfer_cfg_t           cfg;
    ratio_t              new_lead, new_rest;
    logic                expire, tm_load, last_bit, accept;
    ratio_t              tm_val;
    shift_cmd_t          cmd;
    logic [CHAR_LEN-1:0] rx_word;

    spi_rate_calc u_rate (
        .baud     (baud),
        .lead_len (new_lead),
        .rest_len (new_rest)
    );

    spi_half_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .expire   (expire)
    );

    spi_shift_unit #(.CHAR_LEN(CHAR_LEN)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .tx_word  (tx_data),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word),
        .last_bit (last_bit)
    );

    always_comb begin
        accept     = (st == XS_IDLE) && start;
        cmd.load   = accept;
        cmd.sample = (st == XS_ACTIVE) && expire;
        cmd.launch = (st == XS_REST) && expire;
        cmd.finish = (st == XS_TAIL) && expire;
        tm_load    = accept || cmd.sample || cmd.launch;
        if (accept)          tm_val = new_lead - RATIO_W'(1);
        else if (cmd.sample) tm_val = cfg.rest_len - RATIO_W'(1);
        else                 tm_val = cfg.lead_len - RATIO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= XS_IDLE;
            cfg     <= '0;
            sclk    <= cpol;
            cs_n    <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_data <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                XS_IDLE: begin
                    sclk <= cpol;
                    if (start) begin
                        cfg  <= '{pol: cpol, lead_len: new_lead, rest_len: new_rest};
                        sclk <= ~cpol;
                        cs_n <= 1'b0;
                        busy <= 1'b1;
                        st   <= XS_ACTIVE;
                    end
                end
                XS_ACTIVE: if (expire) begin
                    sclk <= cfg.pol;
                    st   <= last_bit ? XS_TAIL : XS_REST;
                end
                XS_REST: if (expire) begin
                    sclk <= ~cfg.pol;
                    st   <= XS_ACTIVE;
                end
                XS_TAIL: if (expire) begin
                    cs_n    <= 1'b1;
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    rx_data <= rx_word;
                    st      <= XS_IDLE;
                end
                default: st <= XS_IDLE;
            endcase
        end
    end

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_select_tracks_busy: assert property (@(posedge clk) disable iff (rst)
        busy == !cs_n);
    a_r3_rest_level: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));
    a_r8_config_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg));
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start && !cmd.finish) |=> busy);
endmodule

// File: tb/spi_baud_master_test.sv
module spi_baud_master_test;
    localparam int LEN = 8;

    typedef struct {
        logic [LEN-1:0] tx;
        logic [LEN-1:0] sw;
        int             n;
        logic           pol;
    } exp_t;

    logic           clk = 0, rst = 1, start = 0, cpol = 0, miso = 0;
    logic [6:0]     baud = 0;
    logic [LEN-1:0] tx_data = 0;
    logic           busy, done, sclk, mosi, cs_n;
    logic [LEN-1:0] rx_data;

    int checks = 0, errors = 0;
    exp_t q[$];

    spi_baud_master #(.CHAR_LEN(LEN)) uut (
        .clk(clk), .rst(rst), .start(start), .baud(baud), .cpol(cpol),
        .tx_data(tx_data), .miso(miso), .busy(busy), .done(done),
        .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic int n_of(input int b);
        return (b < 3) ? 4 : b + 1;
    endfunction

    // monitor and slave model, sampling at the falling clock edge
    int   cyc = 0, t_start = 0, t_fall = 0, nfall = 0, sidx = 0;
    logic prev_busy = 0, prev_sclk = 0;
    logic [LEN-1:0] mosi_acc = 0;
    exp_t cur;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (busy && !prev_busy) begin
                chk(q.size() != 0, "R7 unexpected transfer", q.size(), 1);
                if (q.size() != 0) cur = q.pop_front();
                t_start = cyc; nfall = 0; sidx = 0; mosi_acc = 0;
                chk(cs_n == 0, "R4 select low at start", cs_n, 0);
                chk(mosi == cur.tx[LEN-1], "R4 first bit on mosi", mosi, cur.tx[LEN-1]);
            end
            if (busy && sclk != prev_sclk && sclk == ~cur.pol) begin
                if (sidx < LEN) miso <= cur.sw[LEN-1-sidx];
                sidx++;
            end
            if (busy && sclk != prev_sclk && sclk == cur.pol) begin
                if (nfall == 0)
                    chk(cyc - t_start == cur.n / 2, "R2 first active half", cyc - t_start, cur.n / 2);
                else
                    chk(cyc - t_fall == cur.n, "R1 sampling edge spacing", cyc - t_fall, cur.n);
                mosi_acc = {mosi_acc[LEN-2:0], mosi};
                t_fall = cyc;
                nfall++;
            end
            if (!busy && prev_busy) begin
                chk(cyc - t_start == LEN * cur.n, "R6 busy length", cyc - t_start, LEN * cur.n);
                chk(cyc - t_fall == cur.n - cur.n / 2, "R6 tail after last sample",
                    cyc - t_fall, cur.n - cur.n / 2);
                chk(done == 1 && cs_n == 1, "R6 done and select release", {done, cs_n}, 3);
                chk(nfall == LEN, "R5 sampling edge count", nfall, LEN);
                chk(rx_data == cur.sw, "R5 received word", rx_data, cur.sw);
                chk(mosi_acc == cur.tx, "R4 transmitted word", mosi_acc, cur.tx);
            end
        end
        prev_busy = busy;
        prev_sclk = sclk;
    end

    // mode 0: plain, mode 1: extra start while busy, mode 2: inputs changed while busy
    task automatic xfer(input logic [LEN-1:0] tx, input logic [LEN-1:0] sw,
                        input int b, input logic pol, input int mode);
        exp_t e;
        @(negedge clk);
        cpol = pol; baud = 7'(b); tx_data = tx;
        repeat (2) @(negedge clk);
        e.tx = tx; e.sw = sw; e.n = n_of(b); e.pol = pol;
        q.push_back(e);
        start = 1;
        @(negedge clk);
        start = 0;
        if (mode == 1) begin
            repeat (3) @(negedge clk);
            start = 1; tx_data = ~tx;
            @(negedge clk);
            start = 0;
        end
        if (mode == 2) begin
            repeat (3) @(negedge clk);
            baud = 7'd0; cpol = ~pol; tx_data = ~tx;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(done == 0, "R6 done is a single pulse", done, 0);
        chk(busy == 0, "R7 no second transfer", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(sclk == 0 && cs_n == 1 && busy == 0 && done == 0, "R3 reset state",
            {sclk, cs_n, busy, done}, 4'b0100);
        cpol = 1;
        repeat (2) @(negedge clk);
        chk(sclk == 1, "R3 rest level follows polarity", sclk, 1);
        cpol = 0;
        repeat (2) @(negedge clk);
        chk(sclk == 0, "R3 rest level low", sclk, 0);

        xfer(8'hA5, 8'h3C, 0,   0, 0);   // R1 forced ratio 4
        xfer(8'h00, 8'hFF, 1,   0, 0);
        xfer(8'hFF, 8'h00, 2,   0, 0);
        xfer(8'h81, 8'h7E, 3,   0, 0);   // R1 threshold
        xfer(8'h5A, 8'hC3, 4,   0, 0);   // R2 odd ratio 5
        xfer(8'h3C, 8'h96, 7,   1, 0);   // R2 even ratio, polarity 1
        xfer(8'hC6, 8'h1B, 10,  1, 0);   // R2 odd ratio 11, polarity 1
        xfer(8'h69, 8'hE4, 127, 0, 0);   // R1 largest ratio
        xfer(8'h9F, 8'h42, 5,   0, 1);   // R7
        xfer(8'h27, 8'hD8, 6,   1, 2);   // R8
        @(negedge clk);
        chk(sclk == 0, "R8 rest level takes new polarity after transfer", sclk, 0);
        chk(q.size() == 0, "R7 all transfers seen", q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired, actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule